// File: doc/BRIEF.md
# SPI Controller Event and Interrupt Collector

This block gathers the status events of an SPI controller into a bank of sticky flags and turns them into a single interrupt request. The FIFOs and the shift engine each raise a one-cycle pulse on their own event input. The matching flag holds that event until software acknowledges it. Each event also has a mask bit, and a set mask bit keeps that event from reaching the interrupt.

Software reaches the block through a simple register port with a write strobe, a write address, write data and a separate read address. A write to the event register clears every flag whose data bit is one. A write to the mask register replaces the whole mask. A read-only status register gives a summary pending bit. An interrupt handler reads this bit first, and it treats an interrupt that arrives while the bit is low as spurious. To quiesce the controller after reset or after a fault, software masks all events and acknowledges all of them.

Top module: `spi_evt_irq`

## Requirements
- R1: After reset all event flags read 0, all mask bits read 1, and both `irq_o` and `pend_o` are 0.
- R2: A pulse on `evt_pulse_i[k]` sets event flag k at the next rising clock edge. The flag then stays set until it is cleared. The flag positions are: 0 master done, 1 slave done, 2 transmit underflow, 3 transmit overflow, 4 transmit request, 5 receive underflow, 6 receive overflow, 7 receive request, 8 multiple-master error.
- R3: A write to address 0 (event register) clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value. A read of address 0 returns the flags in bits 8:0.
- R4: If an event pulse and a write-one clear hit the same flag in the same cycle, the flag is set after that edge.
- R5: A write to address 1 (mask register) loads bits 8:0 of the write data into the mask. A read of address 1 returns the mask.
- R6: An event whose mask bit is 1 is still recorded in its flag, but it raises neither `pend_o` nor `irq_o`.
- R7: `pend_o` is 1 exactly when at least one flag is set and its mask bit is 0. A read of address 2 (status) returns `pend_o` in bit 0 and zeros in every other bit.
- R8: `irq_o` is a registered copy of the pending condition, one clock cycle behind `pend_o`.
- R9: Writes to address 2 or address 3 change neither the flags nor the mask. A read of address 3 returns 0.
- R10: Writing all ones to the mask and then all ones to the event register leaves every flag clear, with `pend_o` low at once and `irq_o` low one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_pulse_i | input | 9 | Single-cycle event pulses, one per flag position |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 9 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 9 | Read data for `rd_addr_i`, combinational |
| pend_o | output | 1 | Summary pending: some unmasked flag is set |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume that every input is synchronous to the clock and stable around its rising edge. They also assume that reset is the only way the state returns to its initial values, so each property is disabled while reset is low. The bench changes all inputs on the falling edge. Event pulses arrive in any combination, including on the same cycle as a clear of the same flag. Writes to the two unused addresses are mixed in. Reset is applied again in the middle of the run, and always from the falling edge, so the asynchronous clear never lands on an active edge.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

    // Number of controller events collected by the unit.
    localparam int EVT_COUNT = 9;

    // Flag positions inside the event and mask registers.
    localparam int EV_MASTER_DONE = 0;
    localparam int EV_SLAVE_DONE  = 1;
    localparam int EV_TX_UNDER    = 2;
    localparam int EV_TX_OVER     = 3;
    localparam int EV_TX_REQ      = 4;
    localparam int EV_RX_UNDER    = 5;
    localparam int EV_RX_OVER     = 6;
    localparam int EV_RX_REQ      = 7;
    localparam int EV_MM_ERR      = 8;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_EVENT  = 2'd0,
        RA_MASK   = 2'd1,
        RA_STATUS = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/evt_sticky.sv
module evt_sticky #(
    parameter int N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pulse_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] evt_o
);

    typedef struct packed {
        logic [N-1:0] evt;
    } sticky_st_t;

    sticky_st_t st_d, st_q;

    // Arrival wins over acknowledge on the same flag.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            st_d.evt[i] = (st_q.evt[i] & ~clr_i[i]) | pulse_i[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

    for (genvar g = 0; g < N; g++) begin : g_bit_chk
        // R2
        set_on_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pulse_i[g] |=> evt_o[g]);
        // R2
        no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!evt_o[g] && !pulse_i[g]) |=> !evt_o[g]);
        // R3
        hold_unless_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_o[g] && !clr_i[g]) |=> evt_o[g]);
        // R3
        clear_takes_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[g] && !pulse_i[g]) |=> !evt_o[g]);
    end

endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
    parameter int N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [N-1:0] data_i,
    output logic [N-1:0] mask_o
);

    typedef struct packed {
        logic [N-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.mask = data_i;
        end
    end

    // Every event starts silenced.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

    // R5
    mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (mask_o == $past(data_i)));
    // R5
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(mask_o));

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int N = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] mask_i,
    output logic         pend_o,
    output logic         irq_o
);

    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t     st_d, st_q;
    logic [N-1:0] live;

    always_comb begin
        live   = evt_i & ~mask_i;
        pend_o = |live;
        st_d   = st_q;
        st_d.irq = pend_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R8
    irq_follows_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o |=> irq_o);
    // R8
    irq_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_o |=> !irq_o);
    // R6
    masked_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_i & ~mask_i) == '0) |=> !irq_o);

endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
    import spi_evt_pkg::*;
#(
    parameter int N = 9
) (
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [N-1:0]          wr_data_i,
    input  logic [REG_ADDR_W-1:0] rd_addr_i,
    input  logic [N-1:0]          evt_i,
    input  logic [N-1:0]          mask_i,
    input  logic                  pend_i,
    output logic [N-1:0]          clr_o,
    output logic                  mask_ld_o,
    output logic [N-1:0]          rd_data_o
);

    always_comb begin
        clr_o     = '0;
        mask_ld_o = 1'b0;
        if (wr_en_i) begin
            case (wr_addr_i)
                RA_EVENT: clr_o     = wr_data_i;
                RA_MASK:  mask_ld_o = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            RA_EVENT:  rd_data_o = evt_i;
            RA_MASK:   rd_data_o = mask_i;
            RA_STATUS: rd_data_o[0] = pend_i;
            default:   rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq
    import spi_evt_pkg::*;
#(
    parameter int N = EVT_COUNT
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N-1:0]          evt_pulse_i,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [N-1:0]          wr_data_i,
    input  logic [REG_ADDR_W-1:0] rd_addr_i,
    output logic [N-1:0]          rd_data_o,
    output logic                  pend_o,
    output logic                  irq_o
);

    logic [N-1:0] evt_w;
    logic [N-1:0] mask_w;
    logic [N-1:0] clr_w;
    logic         mask_ld_w;

    evt_reg_port #(.N(N)) u_port (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .evt_i     (evt_w),
        .mask_i    (mask_w),
        .pend_i    (pend_o),
        .clr_o     (clr_w),
        .mask_ld_o (mask_ld_w),
        .rd_data_o (rd_data_o)
    );

    evt_sticky #(.N(N)) u_sticky (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pulse_i (evt_pulse_i),
        .clr_i   (clr_w),
        .evt_o   (evt_w)
    );

    evt_mask_reg #(.N(N)) u_mask (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (mask_ld_w),
        .data_i (wr_data_i),
        .mask_o (mask_w)
    );

    irq_summary #(.N(N)) u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_w),
        .mask_i (mask_w),
        .pend_o (pend_o),
        .irq_o  (irq_o)
    );

    // R7
    status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == RA_STATUS) |-> (rd_data_o[0] == pend_o));
    // R9
    spare_write_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_addr_i == RA_STATUS || wr_addr_i == RA_SPARE)) |=> $stable(mask_w));
    // R9
    spare_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == RA_SPARE) |-> (rd_data_o == '0));

endmodule

// File: tb/spi_evt_irq_bench.sv
`timescale 1ns/1ps
module spi_evt_irq_bench;

    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pulse = '0;
    logic         we = 1'b0;
    logic [1:0]   waddr = '0;
    logic [N-1:0] wdata = '0;
    logic [1:0]   raddr = '0;
    logic [N-1:0] rd_data;
    logic         pend;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    // Behavioural reference state
    logic [N-1:0] m_evt  = '0;
    logic [N-1:0] m_mask = '1;
    logic         m_irq  = 1'b0;

    always #2 clk = ~clk;

    spi_evt_irq u_spi_evt_irq (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .evt_pulse_i (pulse),
        .wr_en_i     (we),
        .wr_addr_i   (waddr),
        .wr_data_i   (wdata),
        .rd_addr_i   (raddr),
        .rd_data_o   (rd_data),
        .pend_o      (pend),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_evt;
            2'd1: return m_mask;
            2'd2: return {{(N-1){1'b0}}, |(m_evt & ~m_mask)};
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_evt  = '0;
            m_mask = '1;
            m_irq  = 1'b0;
        end else begin
            m_irq = |(m_evt & ~m_mask);
            if (we && waddr == 2'd0) m_evt = m_evt & ~wdata;
            m_evt = m_evt | pulse;
            if (we && waddr == 2'd1) m_mask = wdata;
        end
    end

    always @(posedge clk) begin
        #1;
        if (cmp_en) begin
            check("R8 irq per cycle", 32'(irq), 32'(m_irq));
            check("R7 pend per cycle", 32'(pend), 32'(|(m_evt & ~m_mask)));
            case (raddr)
                2'd0: check("R2 R3 event read", 32'(rd_data), 32'(model_read(raddr)));
                2'd1: check("R5 mask read", 32'(rd_data), 32'(model_read(raddr)));
                2'd2: check("R7 status read", 32'(rd_data), 32'(model_read(raddr)));
                default: check("R9 spare read", 32'(rd_data), 32'(model_read(raddr)));
            endcase
        end
    end

    task automatic step(input logic [N-1:0] p, input logic w, input logic [1:0] wa,
                        input logic [N-1:0] wd, input logic [1:0] ra);
        @(negedge clk);
        pulse = p;
        we    = w;
        waddr = wa;
        wdata = wd;
        raddr = ra;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pulse = '0;
        we    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400us;
        errors++;
        $display("FAIL watchdog R1 actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        cmp_en = 1'b1;

        // R1 reset state
        step('0, 1'b0, 2'd0, '0, 2'd1);
        check("R1 mask reset", 32'(rd_data), 32'h1FF);
        check("R1 irq reset", 32'(irq), 0);
        check("R1 pend reset", 32'(pend), 0);
        step('0, 1'b0, 2'd0, '0, 2'd0);
        check("R1 events reset", 32'(rd_data), 0);

        // R6 masked event recorded, silent
        step(9'h008, 1'b0, 2'd0, '0, 2'd0);
        check("R2 tx overflow flag", 32'(rd_data), 32'h008);
        check("R6 masked pend", 32'(pend), 0);
        step('0, 1'b0, 2'd0, '0, 2'd2);
        check("R6 masked irq", 32'(irq), 0);

        // R5 unmask bit 3; R7 immediate; R8 one cycle later
        step('0, 1'b1, 2'd1, 9'h1F7, 2'd1);
        check("R5 mask readback", 32'(rd_data), 32'h1F7);
        check("R7 pend after unmask", 32'(pend), 1);
        check("R8 irq not yet", 32'(irq), 0);
        step('0, 1'b0, 2'd0, '0, 2'd2);
        check("R7 status bit", 32'(rd_data), 1);
        check("R8 irq delayed", 32'(irq), 1);

        // R3 write-one clear
        step('0, 1'b1, 2'd0, 9'h008, 2'd0);
        check("R3 cleared", 32'(rd_data), 0);
        check("R3 pend low", 32'(pend), 0);
        step('0, 1'b0, 2'd0, '0, 2'd0);
        check("R8 irq falls", 32'(irq), 0);

        // R4 arrival beats clear
        step(9'h020, 1'b0, 2'd0, '0, 2'd0);
        step(9'h020, 1'b1, 2'd0, 9'h020, 2'd0);
        check("R4 set wins", 32'(rd_data), 32'h020);
        step('0, 1'b1, 2'd0, 9'h000, 2'd0);
        check("R3 zero write keeps", 32'(rd_data), 32'h020);
        step(9'h100, 1'b0, 2'd0, '0, 2'd0);
        check("R2 mm error position", 32'(rd_data), 32'h120);

        // R9 writes to status and spare addresses
        step('0, 1'b1, 2'd2, 9'h000, 2'd1);
        check("R9 status write ignored", 32'(rd_data), 32'h1F7);
        step('0, 1'b1, 2'd3, 9'h1FF, 2'd0);
        check("R9 spare write ignored", 32'(rd_data), 32'h120);
        step('0, 1'b0, 2'd0, '0, 2'd3);
        check("R9 spare read zero", 32'(rd_data), 0);

        // R10 quiesce
        step(9'h1FF, 1'b1, 2'd1, 9'h000, 2'd0);
        step('0, 1'b1, 2'd1, 9'h1FF, 2'd0);
        step('0, 1'b1, 2'd0, 9'h1FF, 2'd0);
        check("R10 all cleared", 32'(rd_data), 0);
        check("R10 pend low", 32'(pend), 0);
        step('0, 1'b0, 2'd0, '0, 2'd0);
        check("R10 irq low", 32'(irq), 0);

        // Random traffic against the reference
        for (int k = 0; k < 4000; k++) begin
            if (k % 997 == 996) begin
                do_reset();
            end
            step(N'($urandom) & N'($urandom) & N'($urandom),
                 ($urandom % 3) == 0, 2'($urandom), N'($urandom), 2'($urandom));
        end
        step('0, 1'b0, 2'd0, '0, 2'd0);
        finish_run();
    end

endmodule